// File: doc/BRIEF.md
# Strip Cluster Finder

This block receives digitised strip charges from a silicon strip readout. One strip arrives per clock: an 8-bit ADC code, the strip's index and a marker for the last strip of a readout chip. The block groups neighbouring strips that carry enough charge into clusters. For each cluster whose total charge is large enough, it reports where the cluster starts, how many strips it spans and its summed charge. A minimum-ionizing particle deposits about 25 counts, so the default cuts keep real hits and drop isolated noise.

Two cuts apply. A per-strip cut decides whether a strip belongs to a cluster. A cut on the summed charge decides whether a finished cluster is reported. A strip below the per-strip cut ends the open cluster. So does a strip whose index is not one more than the previous member's. The end-of-chip marker ends the open cluster as well, including the strip that carries it. Both cuts sit in registers that can be reloaded between beats.

Top module: `strip_cluster_finder`

## Requirements
- R1: After reset, `out_valid` is low, the per-strip cut is 6 counts and the cluster cut is 12 counts.
- R2: A strip belongs to a cluster only when it is presented with `in_valid` high and its ADC code is greater than or equal to the per-strip cut. A strip below the cut never starts or joins a cluster.
- R3: A presented strip below the per-strip cut closes the open cluster. If that cluster is accepted, it is reported in the cycle after the closing strip's clock edge: `out_first` is the first member's index, `out_width` is the member count and `out_charge` is the sum of the members' codes.
- R4: A member strip whose index is not exactly the previous member's index plus one closes the open cluster, reported as in R3. It also opens a new cluster that starts at itself. Index wrap from the maximum value to zero counts as a gap.
- R5: A closed cluster is reported only if its summed charge is greater than or equal to the cluster cut. Otherwise it is discarded with no output.
- R6: A strip presented with `in_last` high ends the chip. If that strip is a member, the cluster containing it is closed and, if accepted, reported in the second cycle after that edge. A cluster closed by the same strip under R3 or R4 is still reported in the first cycle. `in_last` has no effect while `in_valid` is low.
- R7: `out_width` saturates at 127. `out_charge` is 15 bits wide and saturates at 32767.
- R8: A clock edge with `cfg_we` high loads both cuts from `cfg_strip_thr` and `cfg_clus_thr`. The new values apply to strips presented on later edges.
- R9: Cycles with `in_valid` low neither close nor change the open cluster. A member strip presented after idle cycles still extends it when its index is contiguous.
- R10: Each accepted cluster produces exactly one cycle with `out_valid` high, with a width of at least one. No other cycle has `out_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load both cuts on this edge |
| cfg_strip_thr | input | 8 | New per-strip cut |
| cfg_clus_thr | input | 15 | New cluster-sum cut |
| in_valid | input | 1 | A strip is presented this cycle |
| in_index | input | 10 | Strip index |
| in_adc | input | 8 | Strip ADC code |
| in_last | input | 1 | Last strip of the chip |
| out_valid | output | 1 | Cluster descriptor valid |
| out_first | output | 10 | Index of the first strip of the cluster |
| out_width | output | 7 | Number of strips, saturating |
| out_charge | output | 15 | Summed charge, saturating |

## Verification
A cluster closed by a low strip or an index gap is due one cycle after the closing strip's edge. A cluster ended by the chip marker is due two cycles after that edge. Nothing else may raise `out_valid`. The bench's reference model stores each expected descriptor under the number of the clock edge after which it must appear. It then compares the outputs at the falling edge of every cycle, so a report that is early, late, missing or extra is caught at the exact cycle. Dedicated sequences cover the cut boundaries, gaps, idle cycles, the end-of-chip cases, saturation and threshold reloads. A long pseudo-random stream follows them.

// File: rtl/scf_pkg.sv
package scf_pkg;
  localparam int unsigned ADC_BITS   = 8;
  localparam int unsigned SUM_BITS   = 15;
  localparam int unsigned WIDTH_BITS = 7;
  localparam int unsigned IDX_BITS   = 10;
  localparam int unsigned STRIP_CUT_DEFAULT = 6;
  localparam int unsigned CLUS_CUT_DEFAULT  = 12;
endpackage

// File: rtl/scf_thresh_regs.sv
module scf_thresh_regs #(
  parameter int unsigned ADC_W = 8,
  parameter int unsigned SUM_W = 15,
  parameter int unsigned STRIP_DEF = 6,
  parameter int unsigned CLUS_DEF = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [ADC_W-1:0] strip_in,
  input  logic [SUM_W-1:0] clus_in,
  output logic [ADC_W-1:0] strip_cut,
  output logic [SUM_W-1:0] clus_cut
);
  localparam logic [ADC_W-1:0] STRIP_RST = ADC_W'(STRIP_DEF);
  localparam logic [SUM_W-1:0] CLUS_RST  = SUM_W'(CLUS_DEF);

  always_ff @(posedge clk) begin
    if (rst) begin
      strip_cut <= STRIP_RST;
      clus_cut  <= CLUS_RST;
    end else if (we) begin
      strip_cut <= strip_in;
      clus_cut  <= clus_in;
    end
  end
endmodule

// File: rtl/scf_accum.sv
module scf_accum #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned ADC_W = 8,
  parameter int unsigned SUM_W = 15,
  parameter int unsigned WID_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_index,
  input  logic [ADC_W-1:0] in_adc,
  input  logic             in_last,
  input  logic [ADC_W-1:0] strip_cut,
  input  logic [SUM_W-1:0] clus_cut,
  // cluster closed by a low strip or an index gap
  output logic             brk_hit,
  output logic [IDX_W-1:0] brk_first,
  output logic [WID_W-1:0] brk_width,
  output logic [SUM_W-1:0] brk_sum,
  // cluster closed by the end-of-chip strip
  output logic             eoc_hit,
  output logic [IDX_W-1:0] eoc_first,
  output logic [WID_W-1:0] eoc_width,
  output logic [SUM_W-1:0] eoc_sum
);
  localparam logic [WID_W-1:0] WID_MAX = {WID_W{1'b1}};
  localparam logic [SUM_W-1:0] SUM_MAX = {SUM_W{1'b1}};
  localparam logic [WID_W-1:0] WID_ONE = {{(WID_W-1){1'b0}}, 1'b1};
  localparam logic [IDX_W:0]   IDX_ONE = {{IDX_W{1'b0}}, 1'b1};

  logic             open_q;
  logic [IDX_W-1:0] first_q;
  logic [IDX_W-1:0] prev_q;
  logic [WID_W-1:0] width_q;
  logic [SUM_W-1:0] sum_q;

  logic             member;
  logic             contig;
  logic             extend;
  logic [IDX_W:0]   idx_succ;
  logic [SUM_W:0]   sum_wide;
  logic [IDX_W-1:0] nxt_first;
  logic [WID_W-1:0] nxt_width;
  logic [SUM_W-1:0] nxt_sum;

  always_comb begin
    member   = in_adc >= strip_cut;
    idx_succ = {1'b0, prev_q} + IDX_ONE;
    contig   = open_q && (idx_succ == {1'b0, in_index});
    extend   = contig && member;
    sum_wide = {1'b0, sum_q} + {{(SUM_W + 1 - ADC_W){1'b0}}, in_adc};

    if (extend) begin
      nxt_first = first_q;
      nxt_width = (width_q == WID_MAX) ? WID_MAX : width_q + WID_ONE;
      nxt_sum   = sum_wide[SUM_W] ? SUM_MAX : sum_wide[SUM_W-1:0];
    end else begin
      nxt_first = in_index;
      nxt_width = WID_ONE;
      nxt_sum   = {{(SUM_W - ADC_W){1'b0}}, in_adc};
    end

    brk_hit   = in_valid && open_q && !extend && (sum_q >= clus_cut);
    brk_first = first_q;
    brk_width = width_q;
    brk_sum   = sum_q;

    eoc_hit   = in_valid && in_last && member && (nxt_sum >= clus_cut);
    eoc_first = nxt_first;
    eoc_width = nxt_width;
    eoc_sum   = nxt_sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      first_q <= '0;
      prev_q  <= '0;
      width_q <= '0;
      sum_q   <= '0;
    end else if (in_valid) begin
      open_q <= member && !in_last;
      if (member) begin
        first_q <= nxt_first;
        prev_q  <= in_index;
        width_q <= nxt_width;
        sum_q   <= nxt_sum;
      end
    end
  end
endmodule

// File: rtl/scf_out_stage.sv
module scf_out_stage #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned SUM_W = 15,
  parameter int unsigned WID_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             brk_hit,
  input  logic [IDX_W-1:0] brk_first,
  input  logic [WID_W-1:0] brk_width,
  input  logic [SUM_W-1:0] brk_sum,
  input  logic             eoc_hit,
  input  logic [IDX_W-1:0] eoc_first,
  input  logic [WID_W-1:0] eoc_width,
  input  logic [SUM_W-1:0] eoc_sum,
  output logic             slot_busy,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_first,
  output logic [WID_W-1:0] out_width,
  output logic [SUM_W-1:0] out_charge
);
  // End-of-chip reports wait one cycle here. A break can never coincide
  // with a waiting report because the marker leaves no cluster open.
  logic [IDX_W-1:0] slot_first;
  logic [WID_W-1:0] slot_width;
  logic [SUM_W-1:0] slot_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_busy  <= 1'b0;
      slot_first <= '0;
      slot_width <= '0;
      slot_sum   <= '0;
      out_valid  <= 1'b0;
      out_first  <= '0;
      out_width  <= '0;
      out_charge <= '0;
    end else begin
      slot_busy <= eoc_hit;
      if (eoc_hit) begin
        slot_first <= eoc_first;
        slot_width <= eoc_width;
        slot_sum   <= eoc_sum;
      end
      if (brk_hit) begin
        out_valid  <= 1'b1;
        out_first  <= brk_first;
        out_width  <= brk_width;
        out_charge <= brk_sum;
      end else if (slot_busy) begin
        out_valid  <= 1'b1;
        out_first  <= slot_first;
        out_width  <= slot_width;
        out_charge <= slot_sum;
      end else begin
        out_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/strip_cluster_finder.sv
module strip_cluster_finder
  import scf_pkg::*;
#(
  parameter int unsigned IDX_W = IDX_BITS,
  parameter int unsigned ADC_W = ADC_BITS,
  parameter int unsigned SUM_W = SUM_BITS,
  parameter int unsigned WID_W = WIDTH_BITS,
  parameter int unsigned STRIP_DEF = STRIP_CUT_DEFAULT,
  parameter int unsigned CLUS_DEF = CLUS_CUT_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [ADC_W-1:0] cfg_strip_thr,
  input  logic [SUM_W-1:0] cfg_clus_thr,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_index,
  input  logic [ADC_W-1:0] in_adc,
  input  logic             in_last,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_first,
  output logic [WID_W-1:0] out_width,
  output logic [SUM_W-1:0] out_charge
);
  logic [ADC_W-1:0] strip_cut;
  logic [SUM_W-1:0] clus_thr;
  logic             brk_hit, eoc_hit, slot_busy;
  logic [IDX_W-1:0] brk_first, eoc_first;
  logic [WID_W-1:0] brk_width, eoc_width;
  logic [SUM_W-1:0] brk_sum, eoc_sum;

  scf_thresh_regs #(
    .ADC_W(ADC_W), .SUM_W(SUM_W), .STRIP_DEF(STRIP_DEF), .CLUS_DEF(CLUS_DEF)
  ) u_cuts (
    .clk(clk), .rst(rst), .we(cfg_we),
    .strip_in(cfg_strip_thr), .clus_in(cfg_clus_thr),
    .strip_cut(strip_cut), .clus_cut(clus_thr)
  );

  scf_accum #(
    .IDX_W(IDX_W), .ADC_W(ADC_W), .SUM_W(SUM_W), .WID_W(WID_W)
  ) u_acc (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_index(in_index), .in_adc(in_adc), .in_last(in_last),
    .strip_cut(strip_cut), .clus_cut(clus_thr),
    .brk_hit(brk_hit), .brk_first(brk_first), .brk_width(brk_width), .brk_sum(brk_sum),
    .eoc_hit(eoc_hit), .eoc_first(eoc_first), .eoc_width(eoc_width), .eoc_sum(eoc_sum)
  );

  scf_out_stage #(
    .IDX_W(IDX_W), .SUM_W(SUM_W), .WID_W(WID_W)
  ) u_out (
    .clk(clk), .rst(rst),
    .brk_hit(brk_hit), .brk_first(brk_first), .brk_width(brk_width), .brk_sum(brk_sum),
    .eoc_hit(eoc_hit), .eoc_first(eoc_first), .eoc_width(eoc_width), .eoc_sum(eoc_sum),
    .slot_busy(slot_busy),
    .out_valid(out_valid), .out_first(out_first), .out_width(out_width),
    .out_charge(out_charge)
  );
endmodule

// File: rtl/scf_checker.sv
module scf_checker #(
  parameter int unsigned ADC_W = 8,
  parameter int unsigned SUM_W = 15,
  parameter int unsigned WID_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [WID_W-1:0] out_width,
  input logic [SUM_W-1:0] out_charge,
  input logic             slot_busy,
  input logic             brk_hit,
  input logic [SUM_W-1:0] clus_thr
);
  localparam int ADC_MAX = (1 << ADC_W) - 1;
  localparam int WID_MAX = (1 << WID_W) - 1;

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !out_valid);

  assert_min_charge_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(slot_busy)) |-> (out_charge >= $past(clus_thr)));

  assert_one_source_R6: assert property (@(posedge clk) disable iff (rst)
    slot_busy |-> !brk_hit);

  assert_charge_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && int'(out_width) < WID_MAX) |->
      (int'(out_charge) <= int'(out_width) * ADC_MAX));

  assert_idle_silent_R9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !slot_busy) |=> !out_valid);

  assert_width_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_width != '0));
endmodule

bind strip_cluster_finder scf_checker #(
  .ADC_W(ADC_W), .SUM_W(SUM_W), .WID_W(WID_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_width(out_width), .out_charge(out_charge), .slot_busy(slot_busy),
  .brk_hit(brk_hit), .clus_thr(clus_thr)
);

// File: tb/sim_strip_cluster_finder.sv
module sim_strip_cluster_finder;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_strip_thr = '0;
  logic [14:0] cfg_clus_thr = '0;
  logic        in_valid = 1'b0;
  logic [9:0]  in_index = '0;
  logic [7:0]  in_adc = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic [9:0]  out_first;
  logic [6:0]  out_width;
  logic [14:0] out_charge;

  strip_cluster_finder u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_strip_thr(cfg_strip_thr),
    .cfg_clus_thr(cfg_clus_thr), .in_valid(in_valid), .in_index(in_index),
    .in_adc(in_adc), .in_last(in_last), .out_valid(out_valid),
    .out_first(out_first), .out_width(out_width), .out_charge(out_charge)
  );

  always #(CLK_P/2) clk = ~clk;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    chk_en = 1'b0;
  bit    done = 1'b0;
  string tag = "R1";

  // expected reports, keyed by the edge count after which they must show
  int    exp_first[int];
  int    exp_width[int];
  int    exp_sum[int];
  string exp_tag[int];

  // reference model state
  int m_sthr = 6, m_cthr = 12;
  bit m_open = 0;
  int m_first, m_width, m_sum, m_prev;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int edge_no, int f, int w, int s);
    exp_first[edge_no] = f;
    exp_width[edge_no] = w;
    exp_sum[edge_no]   = s;
    exp_tag[edge_no]   = tag;
  endtask

  task automatic model(int idx, int adc, bit last);
    bit mem, joins;
    mem   = adc >= m_sthr;
    joins = m_open && mem && (idx == m_prev + 1);
    if (m_open && !joins && m_sum >= m_cthr)
      expect_at(cyc + 1, m_first, m_width, m_sum);
    if (mem) begin
      if (joins) begin
        m_width = (m_width >= 127) ? 127 : m_width + 1;
        m_sum   = (m_sum + adc > 32767) ? 32767 : m_sum + adc;
      end else begin
        m_first = idx; m_width = 1; m_sum = adc;
      end
      m_prev = idx;
      m_open = 1;
    end else m_open = 0;
    if (last) begin
      if (m_open && m_sum >= m_cthr) expect_at(cyc + 2, m_first, m_width, m_sum);
      m_open = 0;
    end
  endtask

  task automatic beat(int idx, int adc, bit last = 0);
    @(negedge clk);
    cfg_we = 0; in_valid = 1; in_index = idx[9:0]; in_adc = adc[7:0]; in_last = last;
    model(idx, adc, last);
  endtask

  task automatic idle(int n = 1, bit last = 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_we = 0; in_valid = 0; in_last = last; in_adc = 8'hFF;
    end
  endtask

  task automatic load_cuts(int s, int c);
    @(negedge clk);
    in_valid = 0; in_last = 0; cfg_we = 1;
    cfg_strip_thr = s[7:0]; cfg_clus_thr = c[14:0];
    m_sthr = s; m_cthr = c;
  endtask

  always @(negedge clk) begin
    if (chk_en && !done) begin
      n_chk++;
      if (exp_first.exists(cyc)) begin
        if (!(out_valid === 1'b1 && int'(out_first) == exp_first[cyc] &&
              int'(out_width) == exp_width[cyc] && int'(out_charge) == exp_sum[cyc])) begin
          n_fail++;
          $display("FAIL %s edge %0d: got v=%0b first=%0d width=%0d charge=%0d, expected v=1 first=%0d width=%0d charge=%0d",
                   exp_tag[cyc], cyc, out_valid, out_first, out_width, out_charge,
                   exp_first[cyc], exp_width[cyc], exp_sum[cyc]);
        end
        exp_first.delete(cyc); exp_width.delete(cyc);
        exp_sum.delete(cyc); exp_tag.delete(cyc);
      end else if (out_valid !== 1'b0) begin
        n_fail++;
        $display("FAIL %s/R10 edge %0d: got out_valid=%0b first=%0d width=%0d charge=%0d, expected out_valid=0",
                 tag, cyc, out_valid, out_first, out_width, out_charge);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: got no completion, expected end within limit");
    finish_run();
  end

  initial begin
    int idx;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got out_valid=%0b, expected 0", out_valid);
    end
    chk_en = 1;

    // R1/R2/R5 with default cuts: 5 is not a member, 6+6 = 12 is accepted
    tag = "R1";
    beat(0, 5); beat(1, 6); beat(2, 6); beat(3, 5); idle(3);
    tag = "R2";
    beat(5, 5); beat(6, 5); beat(7, 0); idle(3);

    // R3: low strip ends a three-strip cluster
    tag = "R3";
    beat(10, 20); beat(11, 30); beat(12, 25); beat(13, 0); idle(3);

    // R4: index gaps
    tag = "R4";
    beat(40, 50); beat(42, 50); beat(43, 3); idle(2);
    beat(60, 30); beat(61, 30); beat(63, 30); beat(64, 30); beat(70, 9); beat(71, 9); beat(72, 0); idle(3);

    // R5: below-cut sums are dropped, equal sum kept
    tag = "R5";
    beat(80, 11); beat(81, 0); beat(83, 7); beat(84, 5); beat(86, 6); beat(87, 5); idle(1);
    beat(90, 6); beat(91, 5); beat(92, 6); beat(93, 6); beat(94, 0); idle(3);

    // R6: end-of-chip cases
    tag = "R6";
    beat(100, 40); beat(101, 40, 1); idle(3);
    beat(110, 40); beat(111, 2, 1); idle(3);
    beat(120, 40); beat(122, 40, 1); idle(3);
    beat(130, 30, 1); beat(131, 30, 1); beat(140, 30, 1); idle(3);
    beat(150, 30); idle(2, 1); beat(151, 30); beat(152, 0); idle(3);

    // R7: saturation of width and charge
    tag = "R7";
    for (int i = 0; i < 130; i++) beat(200 + i, 255);
    beat(330, 0); idle(3);
    for (int i = 0; i < 128; i++) beat(400 + i, 255);
    beat(528, 1); idle(3);

    // R8: reloaded cuts
    tag = "R8";
    load_cuts(20, 100);
    beat(600, 15); beat(601, 30); beat(602, 40); beat(603, 35); beat(604, 19); idle(1);
    beat(610, 30); beat(611, 30); beat(612, 30); beat(613, 0); idle(3);
    load_cuts(6, 12);
    beat(620, 6); beat(621, 6); beat(622, 0); idle(3);

    // R9: idle cycles inside a cluster
    tag = "R9";
    beat(700, 10); idle(4); beat(701, 10); idle(2); beat(702, 10); beat(703, 0); idle(3);

    // R10: pseudo-random stream
    tag = "R10";
    idx = 0;
    for (int n = 0; n < 1500; n++) begin
      int a;
      bit lst;
      if ($urandom_range(0, 4) == 0) idle($urandom_range(1, 3));
      a = ($urandom_range(0, 1) == 0) ? $urandom_range(0, 5) : $urandom_range(0, 255);
      lst = (idx > 1000) || ($urandom_range(0, 39) == 0);
      beat(idx, a, lst);
      if (lst) idx = $urandom_range(0, 20);
      else idx = idx + (($urandom_range(0, 9) == 0) ? 2 : 1);
    end
    idle(5);
    finish_run();
  end
endmodule